// File: doc/BRIEF.md
# Overcurrent Hiccup Fault Sequencer

This block is the digital side of a switching regulator's overcurrent protection. Each switching cycle starts with a one-clock strobe. An overcurrent comparator flag can arrive at any clock inside the cycle. When it does, the high-side gate is blanked in the same clock and stays blanked until the next cycle strobe. The sequencer counts switching cycles that contain an overcurrent event. A cycle with no event breaks the run, so only back-to-back events count.

When the run reaches the trip count, the converter is shut down and an overcurrent fault is raised. A hiccup wait of several soft-start periods then begins. At the end of the wait the run count is cleared, the fault drops and a one-clock request starts a new soft-start. If the overload has gone by then, the converter returns to regulation through the normal soft-start. If it is still there, the same sequence repeats. Deasserting the enable stops switching at once and clears all fault state. Raising the enable requests a soft-start.

Top module: `ocp_hiccup_seq`

## Requirements
- R1: After reset, and one clock after `en` is sampled low, `shutdown`=1, `hs_block`=1, `fault_oc`=0 and `ss_restart`=0.
- R2: One clock after `en` is first sampled high, `ss_restart` is high for exactly one clock and `shutdown` falls. The sequencer stays in soft-start until `ss_done` is sampled high, then it regulates.
- R3: While switching, `hs_block` rises in the same clock that `oc_flag` is high, without waiting for a clock edge. It stays high for the rest of that switching cycle and falls in the clock in which `cyc_start` next goes high, unless `oc_flag` is high in that clock.
- R4: A switching cycle with `oc_flag` high in any of its clocks is one detection. Several flagged clocks in one cycle still count once. Detections are counted during soft-start and during regulation. `shutdown` and `fault_oc` rise one clock after the detection that completes TRIP_COUNT consecutive cycles (17 by default). A run of TRIP_COUNT-1 does not trip.
- R5: A switching cycle that ends with no detection resets the run. After that, a full TRIP_COUNT further consecutive detections are needed to trip.
- R6: After a trip, `shutdown` and `fault_oc` stay high for exactly HICCUP_PERIODS × SS_PERIOD_CLKS clocks (8 soft-start periods). Both then fall in the same clock in which `ss_restart` pulses high for one clock.
- R7: The run count is zero after a hiccup retry. A new trip needs a full TRIP_COUNT consecutive detections.
- R8: If no overcurrent occurs after a retry, the converter keeps running with `shutdown`=0 and `fault_oc`=0.
- R9: Deasserting `en` clears the run count, the hiccup timer and `fault_oc` on the next clock, even in the middle of a hiccup wait. After re-enable a full run is needed to trip.
- R10: During a hiccup wait, `oc_flag` and `cyc_start` have no effect. The wait length and the outputs do not change.
- R11: Whenever `shutdown` is high, `hs_block` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Converter enable; low stops switching and clears fault state |
| cyc_start | input | 1 | One-clock strobe marking the first clock of each switching cycle |
| oc_flag | input | 1 | Overcurrent comparator output, synchronous to `clk` |
| ss_done | input | 1 | Soft-start ramp has finished |
| hs_block | output | 1 | High-side gate blanking; high forces the switch off |
| shutdown | output | 1 | Converter is stopped (disabled or in hiccup wait) |
| ss_restart | output | 1 | One-clock request to begin a soft-start ramp |
| fault_oc | output | 1 | Overcurrent fault active during the hiccup wait |

## Verification
The assertions assume that `oc_flag`, `cyc_start`, `ss_done` and `en` are already synchronous to `clk`. They also assume that `cyc_start` is a single-clock strobe and never held high. The stimulus drives every input a short time after the rising edge and keeps each switching cycle four clocks long with the strobe in its first clock. Overcurrent is raised only after the strobe clock, so no detection is ever tied to a cycle boundary. Inside the hiccup wait, the bench deliberately drives overcurrent and strobes that break these habits, to show they are ignored.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SOFT   = 2'd1,
        ST_RUN    = 2'd2,
        ST_HICCUP = 2'd3
    } seq_state_e;

    // Per-clock events derived from the comparator within a switching cycle
    typedef struct packed {
        logic detect;    // first overcurrent clock of a cycle
        logic clean_end; // a cycle just ended with no overcurrent
    } cyc_evt_t;

    // The power stage switches only while ramping or regulating
    function automatic logic is_switching(input seq_state_e st);
        return (st == ST_SOFT) || (st == ST_RUN);
    endfunction

    function automatic logic is_stopped(input seq_state_e st);
        return (st == ST_OFF) || (st == ST_HICCUP);
    endfunction

endpackage

// File: rtl/ocp_cycle_monitor.sv
module ocp_cycle_monitor
    import ocp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     active,
    input  logic     cyc_start,
    input  logic     oc_flag,
    output cyc_evt_t evt,
    output logic     seen_q
);

    logic seen_d;

    // Remember whether the current switching cycle has already seen overcurrent
    always_comb begin
        if (!active) begin
            seen_d = 1'b0;
        end else if (cyc_start) begin
            seen_d = oc_flag;
        end else begin
            seen_d = seen_q | oc_flag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= seen_d;
        end
    end

    always_comb begin
        evt.detect    = active & oc_flag & (cyc_start | ~seen_q);
        evt.clean_end = active & cyc_start & ~seen_q;
    end

endmodule

// File: rtl/ocp_run_counter.sv
module ocp_run_counter
    import ocp_pkg::*;
#(
    parameter int TRIP_COUNT = 17
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  cyc_evt_t evt,
    output logic     trip
);

    localparam int CNTW = $clog2(TRIP_COUNT + 1);

    logic [CNTW-1:0] run_q;
    logic [CNTW-1:0] run_base;
    logic [CNTW-1:0] run_d;

    always_comb begin
        run_base = evt.clean_end ? '0 : run_q;
        run_d    = evt.detect ? run_base + CNTW'(1) : run_base;
        trip     = evt.detect && (run_base == CNTW'(TRIP_COUNT - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

endmodule

// File: rtl/ocp_hiccup_timer.sv
module ocp_hiccup_timer #(
    parameter int SS_PERIOD_CLKS = 16,
    parameter int HICCUP_PERIODS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);

    localparam int CW = (SS_PERIOD_CLKS > 1) ? $clog2(SS_PERIOD_CLKS) : 1;
    localparam int PW = (HICCUP_PERIODS > 1) ? $clog2(HICCUP_PERIODS) : 1;

    logic period_tick;

    // Prescaler: one tick per soft-start period
    generate
        if (SS_PERIOD_CLKS > 1) begin : g_prescale
            logic [CW-1:0] clk_cnt_q;
            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    clk_cnt_q <= '0;
                end else if (clk_cnt_q == CW'(SS_PERIOD_CLKS - 1)) begin
                    clk_cnt_q <= '0;
                end else begin
                    clk_cnt_q <= clk_cnt_q + CW'(1);
                end
            end
            assign period_tick = run && (clk_cnt_q == CW'(SS_PERIOD_CLKS - 1));
        end else begin : g_no_prescale
            assign period_tick = run;
        end
    endgenerate

    // Period counter: done on the last clock of the last period
    generate
        if (HICCUP_PERIODS > 1) begin : g_periods
            logic [PW-1:0] per_cnt_q;
            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    per_cnt_q <= '0;
                end else if (period_tick) begin
                    per_cnt_q <= per_cnt_q + PW'(1);
                end
            end
            assign done = period_tick && (per_cnt_q == PW'(HICCUP_PERIODS - 1));
        end else begin : g_single
            assign done = period_tick;
        end
    endgenerate

endmodule

// File: rtl/ocp_seq_fsm.sv
module ocp_seq_fsm
    import ocp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       ss_done,
    input  logic       trip,
    input  logic       wait_done,
    output seq_state_e state,
    output logic       restart_q,
    output logic       fault_q
);

    seq_state_e state_d;
    logic       restart_d;

    always_comb begin
        state_d   = state;
        restart_d = 1'b0;
        if (!en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: begin
                    state_d   = ST_SOFT;
                    restart_d = 1'b1;
                end
                ST_SOFT: begin
                    if (trip) begin
                        state_d = ST_HICCUP;
                    end else if (ss_done) begin
                        state_d = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (trip) begin
                        state_d = ST_HICCUP;
                    end
                end
                ST_HICCUP: begin
                    if (wait_done) begin
                        state_d   = ST_SOFT;
                        restart_d = 1'b1;
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_OFF;
            restart_q <= 1'b0;
            fault_q   <= 1'b0;
        end else begin
            state     <= state_d;
            restart_q <= restart_d;
            fault_q   <= (state_d == ST_HICCUP);
        end
    end

endmodule

// File: rtl/ocp_hiccup_seq.sv
module ocp_hiccup_seq
    import ocp_pkg::*;
#(
    parameter int SS_PERIOD_CLKS = 16,
    parameter int HICCUP_PERIODS = 8,
    parameter int TRIP_COUNT     = 17
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic cyc_start,
    input  logic oc_flag,
    input  logic ss_done,
    output logic hs_block,
    output logic shutdown,
    output logic ss_restart,
    output logic fault_oc
);

    seq_state_e state;
    cyc_evt_t   evt;
    logic       seen_q;
    logic       active;
    logic       trip;
    logic       wait_done;
    logic       in_wait;

    assign active  = is_switching(state);
    assign in_wait = (state == ST_HICCUP);

    ocp_cycle_monitor u_mon (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .cyc_start (cyc_start),
        .oc_flag   (oc_flag),
        .evt       (evt),
        .seen_q    (seen_q)
    );

    ocp_run_counter #(
        .TRIP_COUNT (TRIP_COUNT)
    ) u_run (
        .clk   (clk),
        .rst   (rst),
        .clear (!active),
        .evt   (evt),
        .trip  (trip)
    );

    ocp_hiccup_timer #(
        .SS_PERIOD_CLKS (SS_PERIOD_CLKS),
        .HICCUP_PERIODS (HICCUP_PERIODS)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (in_wait),
        .done (wait_done)
    );

    ocp_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .ss_done   (ss_done),
        .trip      (trip),
        .wait_done (wait_done),
        .state     (state),
        .restart_q (ss_restart),
        .fault_q   (fault_oc)
    );

    // Comparator path to the gate is combinational so the switch opens at once
    assign hs_block = !active || oc_flag || (seen_q && !cyc_start);
    assign shutdown = is_stopped(state);

endmodule

// File: rtl/ocp_hiccup_seq_chk.sv
module ocp_hiccup_seq_chk #(
    parameter int HICCUP_CLKS = 128
) (
    input logic clk,
    input logic rst,
    input logic en,
    input logic cyc_start,
    input logic oc_flag,
    input logic hs_block,
    input logic shutdown,
    input logic ss_restart,
    input logic fault_oc
);

    logic [31:0] fault_len_q;

    always_ff @(posedge clk) begin
        if (rst || !fault_oc) begin
            fault_len_q <= '0;
        end else begin
            fault_len_q <= fault_len_q + 32'd1;
        end
    end

    assert_stop_blanks_R11: assert property (@(posedge clk) disable iff (rst)
        shutdown |-> hs_block);

    assert_blank_holds_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(oc_flag) && !cyc_start && !shutdown) |-> hs_block);

    assert_restart_single_R2: assert property (@(posedge clk) disable iff (rst)
        ss_restart |=> !ss_restart);

    assert_restart_running_R2: assert property (@(posedge clk) disable iff (rst)
        ss_restart |-> !shutdown);

    assert_fault_stops_R6: assert property (@(posedge clk) disable iff (rst)
        fault_oc |-> shutdown);

    assert_wait_bounded_R6: assert property (@(posedge clk) disable iff (rst)
        fault_oc |-> (fault_len_q < HICCUP_CLKS));

    assert_retry_on_clear_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(fault_oc) && $past(en)) |-> ss_restart);

    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!fault_oc && shutdown && !ss_restart));

endmodule

bind ocp_hiccup_seq ocp_hiccup_seq_chk #(
    .HICCUP_CLKS (HICCUP_PERIODS * SS_PERIOD_CLKS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .cyc_start  (cyc_start),
    .oc_flag    (oc_flag),
    .hs_block   (hs_block),
    .shutdown   (shutdown),
    .ss_restart (ss_restart),
    .fault_oc   (fault_oc)
);

// File: tb/ocp_hiccup_seq_tb.sv
module ocp_hiccup_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SS_CLKS    = 12;
    localparam int PERIODS    = 8;
    localparam int TRIP       = 17;
    localparam int WAIT_CLKS  = SS_CLKS * PERIODS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic cyc_start = 1'b0;
    logic oc_flag = 1'b0;
    logic ss_done = 1'b0;
    logic hs_block, shutdown, ss_restart, fault_oc;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ocp_hiccup_seq #(
        .SS_PERIOD_CLKS (SS_CLKS),
        .HICCUP_PERIODS (PERIODS),
        .TRIP_COUNT     (TRIP)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .cyc_start  (cyc_start),
        .oc_flag    (oc_flag),
        .ss_done    (ss_done),
        .hs_block   (hs_block),
        .shutdown   (shutdown),
        .ss_restart (ss_restart),
        .fault_oc   (fault_oc)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // One four-clock switching cycle; sd_det is shutdown right after the detection edge
    task automatic do_cycle(input int oc_len, output logic sd_det);
        cyc_start = 1'b1;
        oc_flag   = 1'b0;
        tick();
        cyc_start = 1'b0;
        oc_flag   = (oc_len > 0);
        tick();
        sd_det  = shutdown;
        oc_flag = (oc_len > 1);
        tick();
        oc_flag = 1'b0;
        tick();
    endtask

    task automatic oc_run(input int n, input string req);
        logic sd;
        for (int i = 0; i < n; i++) begin
            do_cycle((i % 3 == 1) ? 2 : 1, sd);
            chk(req, "no trip inside run", sd, 0);
        end
    endtask

    task automatic enter_run();
        ss_done = 1'b1;
        tick();
        ss_done = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        en  = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1", "shutdown after reset", shutdown, 1);
        chk("R1", "hs_block after reset", hs_block, 1);
        chk("R1", "fault_oc after reset", fault_oc, 0);
        chk("R1", "ss_restart after reset", ss_restart, 0);
    endtask

    task automatic t_start();
        en = 1'b1;
        tick();
        chk("R2", "restart pulse", ss_restart, 1);
        chk("R2", "shutdown released", shutdown, 0);
        tick();
        chk("R2", "restart single clock", ss_restart, 0);
        enter_run();
        chk("R2", "running after ss_done", shutdown, 0);
    endtask

    task automatic t_blank();
        logic sd;
        cyc_start = 1'b1;
        tick();
        cyc_start = 1'b0;
        #1 chk("R3", "gate free before overcurrent", hs_block, 0);
        oc_flag = 1'b1;
        #1 chk("R3", "blank in same clock", hs_block, 1);
        tick();
        oc_flag = 1'b0;
        #1 chk("R3", "blank held after flag drops", hs_block, 1);
        tick();
        chk("R3", "blank held to cycle end", hs_block, 1);
        cyc_start = 1'b1;
        #1 chk("R3", "blank released at next cycle", hs_block, 0);
        tick();
        cyc_start = 1'b0;
        chk("R3", "gate free in clean cycle", hs_block, 0);
        tick();
        tick();
        do_cycle(0, sd);
        chk("R3", "no shutdown", sd, 0);
    endtask

    task automatic t_trip_exact(input string req);
        logic sd;
        oc_run(TRIP - 1, req);
        chk(req, "fault before last event", fault_oc, 0);
        do_cycle(1, sd);
        chk(req, "shutdown at last event", sd, 1);
        chk(req, "fault at last event", fault_oc, 1);
    endtask

    // Entered right after the trip cycle: three high samples already seen
    task automatic t_hiccup();
        int n = 3;
        for (int k = 0; k < 4 * WAIT_CLKS; k++) begin
            oc_flag   = (n >= 10 && n < 30);
            cyc_start = (n >= 10 && n < 30 && (n % 4 == 0));
            tick();
            if (!shutdown) break;
            n++;
        end
        oc_flag   = 1'b0;
        cyc_start = 1'b0;
        chk("R6", "hiccup length in clocks", n, WAIT_CLKS);
        chk("R10", "noise ignored during wait", n, WAIT_CLKS);
        chk("R6", "restart at wait end", ss_restart, 1);
        chk("R6", "fault cleared at wait end", fault_oc, 0);
        tick();
        chk("R6", "restart single clock", ss_restart, 0);
        enter_run();
    endtask

    task automatic t_recover();
        logic sd;
        oc_run(TRIP - 1, "R7");
        for (int i = 0; i < 4; i++) begin
            do_cycle(0, sd);
            chk("R8", "keeps running", shutdown, 0);
        end
        chk("R8", "no fault", fault_oc, 0);
    endtask

    task automatic t_break();
        oc_run(TRIP - 1, "R5");
        begin
            logic sd;
            do_cycle(0, sd);
            chk("R5", "clean cycle", sd, 0);
        end
        oc_run(TRIP - 1, "R5");
        begin
            logic sd;
            do_cycle(1, sd);
            chk("R5", "trip after fresh full run", sd, 1);
        end
    endtask

    task automatic t_disable();
        logic sd;
        oc_run(TRIP - 1, "R9");
        do_cycle(1, sd);
        chk("R9", "tripped", sd, 1);
        tick();
        en = 1'b0;
        tick();
        chk("R9", "fault cleared by disable", fault_oc, 0);
        chk("R1", "shutdown while disabled", shutdown, 1);
        chk("R1", "gate blanked while disabled", hs_block, 1);
        chk("R1", "no restart while disabled", ss_restart, 0);
        en = 1'b1;
        tick();
        chk("R2", "restart on re-enable", ss_restart, 1);
        enter_run();
        oc_run(10, "R9");
        en = 1'b0;
        tick();
        en = 1'b1;
        tick();
        enter_run();
        t_trip_exact("R9");
        en = 1'b0;
        tick();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_start();
        t_blank();
        t_trip_exact("R4");
        t_hiccup();
        t_recover();
        t_break();
        t_hiccup();
        t_disable();
        finish_run();
    end

endmodule